// File: doc/BRIEF.md
# Indirect-access interrupt redirection controller

This block routes up to sixteen interrupt input lines to a set of CPUs. Software programs it through two 32-bit locations on a simple slave bus. One location is a select register that holds an index. The other is a data window that reaches whatever register the index names. Behind the window sit an identification register, a read-only version register, an arbitration register that echoes the identification, and one 64-bit redirection entry per input. Each entry is split into two 32-bit halves on consecutive indices. An entry holds a vector, delivery and destination modes, a trigger mode, a mask bit and a destination number.

The block records the level of each input line. When a line goes from low to high and its entry permits delivery, the block raises a request on a valid/ready port. The request carries the entry's vector and a CPU bitmask: one bit for a single destination, or the active-CPU mask for broadcast. If a level-triggered entry is masked when its line rises, the block marks it pending. When software later unmasks that entry while the line is still high, the block replays the interrupt.

Top module: `irq_router`

## Requirements
- R1: Only accesses with `bus_word`=1 at byte offset 0x00 (select) or 0x10 (window) take effect. Any other access reads 0 and its write changes no register.
- R2: The select register holds a full 32-bit value and reads back at offset 0x00. A window access uses the low 8 bits of select as the index.
- R3: Index 1 reads 0x00100011 (entry count 16 in bits 23:16, version 0x11). Index 2 reads the current ID register. Writes to index 1 and index 2 are ignored.
- R4: A write to index 0 keeps only ID bits 27:24, with every other bit reading 0. An index that matches no register reads 0.
- R5: After reset, select and ID read 0 and every entry reads 0x0001000000010000 (both halves 0x00010000), so every input is masked.
- R6: Entry p sits at indices 0x10+2p (bits 31:0) and 0x11+2p (bits 63:32). A window write replaces that half, and a read returns it.
- R7: Only a low-to-high change of an input can start a delivery. Holding a line high, or taking it low, produces no request.
- R8: A rise is delivered only when mask (bit 16) is 0, destination mode (bit 11) is 0 (physical) and delivery mode (bits 10:8) is 000 (fixed). The request vector is entry bits 7:0.
- R9: Destination bits 63:56 equal to 0xFF give `req_cpus` = `cpu_active`. A value d below 8 gives a mask with only bit d set. A larger value gives a mask of 0.
- R10: A rise on a masked entry with trigger mode bit 15 = 1 (level) sets that entry's pending flag and makes no request. A rise on a masked edge entry (bit 15 = 0) is dropped for good.
- R11: A window write that leaves a pending entry unmasked clears the flag. If the line is then high, exactly one request is produced with the new entry contents. If the line is low, nothing is produced.
- R12: Inputs waiting to be issued go out one per accepted handshake, lowest pin number first. A request holds its vector and mask unchanged while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_in | input | 16 | Interrupt input levels |
| cpu_active | input | 8 | Mask of CPUs that receive broadcasts |
| req_valid | output | 1 | Delivery request present |
| req_ready | input | 1 | Consumer accepts the request |
| req_vector | output | 8 | Vector of the request |
| req_cpus | output | 8 | Destination CPU mask of the request |

## Verification
The hardest case to reach is the deferred replay. It needs a masked level entry whose line rises, then a window write that unmasks the entry while the line is still held high. The same sequence must also be run with the line already released, where nothing may be delivered. The stimulus builds both orderings from bus writes and line changes. After a replay it re-masks and unmasks the entry to show that the pending flag was cleared. A second hard case is three lines rising in one cycle while the consumer stalls. This exposes the lowest-first order and the holding of the request.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ENT_W     = 64;
  localparam int unsigned VEC_LSB   = 0;
  localparam int unsigned DLV_LSB   = 8;
  localparam int unsigned DSTM_BIT  = 11;
  localparam int unsigned TRIG_BIT  = 15;
  localparam int unsigned MASK_BIT  = 16;
  localparam int unsigned DEST_LSB  = 56;

  localparam logic [7:0]  OFS_SEL   = 8'h00;
  localparam logic [7:0]  OFS_WIN   = 8'h10;
  localparam logic [7:0]  IDX_ID    = 8'h00;
  localparam logic [7:0]  IDX_VER   = 8'h01;
  localparam logic [7:0]  IDX_ARB   = 8'h02;
  localparam logic [7:0]  IDX_TBL   = 8'h10;
  localparam logic [7:0]  VER_CODE  = 8'h11;
  localparam logic [31:0] ID_KEEP   = 32'h0F00_0000;
  localparam logic [63:0] ENT_RESET = 64'h0001_0000_0001_0000;

  function automatic logic ent_deliverable(input logic [ENT_W-1:0] e);
    return !e[MASK_BIT] && !e[DSTM_BIT] && (e[DLV_LSB +: 3] == 3'b000);
  endfunction

  function automatic logic ent_defers(input logic [ENT_W-1:0] e);
    return e[MASK_BIT] && e[TRIG_BIT];
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic                       bus_word,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic [NPIN-1:0][ENT_W-1:0] ent_q,
  output logic [NPIN-1:0]            wr_pin_hit,
  output logic [ENT_W-1:0]           wr_entry
);
  localparam int unsigned PIN_W = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam logic [7:0]  TBL_END = IDX_TBL + 8'(2 * NPIN);
  localparam logic [31:0] VER_VAL = {8'd0, 8'(NPIN), 8'd0, VER_CODE};

  logic [31:0] sel_q, sel_d;
  logic [31:0] id_q, id_d;
  logic [NPIN-1:0][ENT_W-1:0] ent_d;

  logic            acc_ok, sel_hit, win_hit, tbl_hit;
  logic [7:0]      idx, tbl_off;
  logic [PIN_W-1:0] tbl_pin;
  logic            tbl_half;
  logic [ENT_W-1:0] cur_ent;

  assign acc_ok   = bus_valid && bus_word;
  assign sel_hit  = acc_ok && (bus_addr == OFS_SEL);
  assign win_hit  = acc_ok && (bus_addr == OFS_WIN);
  assign idx      = sel_q[7:0];
  assign tbl_hit  = (idx >= IDX_TBL) && (idx < TBL_END);
  assign tbl_off  = idx - IDX_TBL;
  assign tbl_pin  = tbl_off[PIN_W:1];
  assign tbl_half = tbl_off[0];

  always_comb begin
    cur_ent = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (tbl_pin == PIN_W'(p)) cur_ent = ent_q[p];
    end
  end

  always_comb begin
    wr_entry = cur_ent;
    if (tbl_half) wr_entry[63:32] = bus_wdata;
    else          wr_entry[31:0]  = bus_wdata;
  end

  always_comb begin
    sel_d = sel_q;
    id_d  = id_q;
    ent_d = ent_q;
    wr_pin_hit = '0;
    if (sel_hit && bus_write) sel_d = bus_wdata;
    if (win_hit && bus_write) begin
      if (idx == IDX_ID) id_d = bus_wdata & ID_KEEP;
      if (tbl_hit) begin
        for (int p = 0; p < NPIN; p++) begin
          if (tbl_pin == PIN_W'(p)) begin
            ent_d[p]      = wr_entry;
            wr_pin_hit[p] = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_hit && !bus_write) begin
      bus_rdata = sel_q;
    end else if (win_hit && !bus_write) begin
      if (idx == IDX_ID || idx == IDX_ARB) bus_rdata = id_q;
      else if (idx == IDX_VER)            bus_rdata = VER_VAL;
      else if (tbl_hit)                   bus_rdata = tbl_half ? cur_ent[63:32] : cur_ent[31:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
      for (int p = 0; p < NPIN; p++) ent_q[p] <= ENT_RESET;
    end else begin
      sel_q <= sel_d;
      id_q  <= id_d;
      ent_q <= ent_d;
    end
  end

  // R1: a rejected access never moves the select or ID registers
  a_r1_bad_access_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !(bus_word && (bus_addr == OFS_SEL || bus_addr == OFS_WIN)))
    |=> ($stable(sel_q) && $stable(id_q)));
  // R3: the arbitration index echoes the ID register
  a_r3_arb_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_word && bus_addr == OFS_WIN && sel_q[7:0] == IDX_ARB)
    |-> (bus_rdata == id_q));
  // R4: ID never holds bits outside the kept field
  a_r4_id_field: assert property (@(posedge clk) disable iff (!rst_n)
    (id_q & ~ID_KEEP) == 32'd0);
  // R6: at most one entry is written per access
  a_r6_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_pin_hit));
endmodule

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl
  import irq_router_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPIN-1:0]            irq_in,
  input  logic [NPIN-1:0][ENT_W-1:0] ent_q,
  input  logic [NPIN-1:0]            wr_pin_hit,
  input  logic [ENT_W-1:0]           wr_entry,
  output logic [NPIN-1:0]            fire_set
);
  logic [NPIN-1:0] pin_q, pend_q, pend_d;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic rise, replay;
    assign rise   = irq_in[p] && !pin_q[p];
    assign replay = wr_pin_hit[p] && pend_q[p] && !wr_entry[MASK_BIT];

    always_comb begin
      fire_set[p] = (rise && ent_deliverable(ent_q[p])) ||
                    (replay && pin_q[p] && ent_deliverable(wr_entry));
      pend_d[p] = pend_q[p];
      if (replay) pend_d[p] = 1'b0;
      if (rise && ent_defers(ent_q[p])) pend_d[p] = 1'b1;
    end

    // R10: a pending flag appears only on a rise of its own line
    a_r10_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[p] && !(irq_in[p] && !pin_q[p])) |=> !pend_q[p]);
    // R11: unmasking a pending entry clears its flag
    a_r11_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pin_hit[p] && pend_q[p] && !wr_entry[MASK_BIT] && !irq_in[p]) |=> !pend_q[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      pend_q <= '0;
    end else begin
      pin_q  <= irq_in;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_router_pkg::*;
#(
  parameter int unsigned NPIN = 16,
  parameter int unsigned NCPU = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPIN-1:0]            fire_set,
  input  logic [NPIN-1:0][ENT_W-1:0] ent_q,
  input  logic [NCPU-1:0]            cpu_active,
  input  logic                       req_ready,
  output logic                       req_valid,
  output logic [7:0]                 req_vector,
  output logic [NCPU-1:0]            req_cpus
);
  logic [NPIN-1:0]  fire_q, fire_d, pick, taken;
  logic             slot_free, load;
  logic [ENT_W-1:0] pick_ent;
  logic [7:0]       dest;
  logic [NCPU-1:0]  cpus_d;
  logic             valid_d;
  logic [7:0]       vec_d;
  logic [NCPU-1:0]  cpus_n;

  assign slot_free = !req_valid || req_ready;
  assign load      = slot_free && (fire_q != '0);
  assign pick      = fire_q & (~fire_q + 1'b1);
  assign taken     = load ? pick : '0;
  assign fire_d    = (fire_q & ~taken) | fire_set;

  always_comb begin
    pick_ent = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (pick[p]) pick_ent = pick_ent | ent_q[p];
    end
  end

  assign dest = pick_ent[DEST_LSB +: 8];

  always_comb begin
    if (dest == 8'hFF)             cpus_d = cpu_active;
    else if (32'(dest) < NCPU)     cpus_d = NCPU'(1) << dest;
    else                           cpus_d = '0;
  end

  always_comb begin
    valid_d = req_valid;
    vec_d   = req_vector;
    cpus_n  = req_cpus;
    if (load) begin
      valid_d = 1'b1;
      vec_d   = pick_ent[VEC_LSB +: 8];
      cpus_n  = cpus_d;
    end else if (req_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q     <= '0;
      req_valid  <= 1'b0;
      req_vector <= '0;
      req_cpus   <= '0;
    end else begin
      fire_q    <= fire_d;
      req_valid <= valid_d;
      if (load) begin
        req_vector <= vec_d;
        req_cpus   <= cpus_n;
      end
    end
  end

  // R12: a stalled request stays put
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_vector) && $stable(req_cpus)));
  // R12: one pin served per load
  a_r12_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken));
  // R7: a new request needs an earlier queued source
  a_r7_req_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && (fire_q == '0)) |=> !req_valid);
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NPIN = 16,
  parameter int unsigned NCPU = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic            bus_word,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] irq_in,
  input  logic [NCPU-1:0] cpu_active,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [7:0]      req_vector,
  output logic [NCPU-1:0] req_cpus
);
  logic [NPIN-1:0][ENT_W-1:0] ent_q;
  logic [NPIN-1:0]            wr_pin_hit;
  logic [ENT_W-1:0]           wr_entry;
  logic [NPIN-1:0]            fire_set;

  irq_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_q(ent_q), .wr_pin_hit(wr_pin_hit), .wr_entry(wr_entry)
  );

  irq_pin_ctl #(.NPIN(NPIN)) u_pins (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ent_q(ent_q),
    .wr_pin_hit(wr_pin_hit), .wr_entry(wr_entry), .fire_set(fire_set)
  );

  irq_dispatch #(.NPIN(NPIN), .NCPU(NCPU)) u_disp (
    .clk(clk), .rst_n(rst_n), .fire_set(fire_set), .ent_q(ent_q),
    .cpu_active(cpu_active), .req_ready(req_ready), .req_valid(req_valid),
    .req_vector(req_vector), .req_cpus(req_cpus)
  );
endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write, bus_word;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] irq_in;
  logic [7:0]  cpu_active;
  logic        req_valid, req_ready;
  logic [7:0]  req_vector, req_cpus;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_in(irq_in), .cpu_active(cpu_active),
    .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
    .req_cpus(req_cpus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected request actual=%h expected=none", {req_vector, req_cpus});
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({req_vector, req_cpus} !== e) begin
          fails++;
          $display("FAIL R12 request actual=%h expected=%h", {req_vector, req_cpus}, e);
        end
      end
    end
  end

  task automatic bus_acc(input logic [7:0] a, input bit word, input bit wr,
                         input logic [31:0] d, output logic [31:0] q);
    @(posedge clk); #1;
    bus_valid = 1; bus_addr = a; bus_word = word; bus_write = wr; bus_wdata = d;
    @(negedge clk); q = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [31:0] d);
    logic [31:0] q;
    bus_acc(8'h00, 1, 1, {24'd0, idx}, q);
    bus_acc(8'h10, 1, 1, d, q);
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [31:0] q);
    logic [31:0] t;
    bus_acc(8'h00, 1, 1, {24'd0, idx}, t);
    bus_acc(8'h10, 1, 0, 32'd0, q);
  endtask

  task automatic set_entry(input int p, input logic [31:0] hi, input logic [31:0] lo);
    wr_reg(8'(8'h11 + 2 * p), hi);
    wr_reg(8'(8'h10 + 2 * p), lo);
  endtask

  task automatic set_pin(input int p, input bit v);
    @(posedge clk); #1;
    irq_in[p] = v;
  endtask

  task automatic quiet(input string req, input int n);
    repeat (n) @(posedge clk);
    check(req, exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] q;
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_word = 0; bus_addr = 0;
    bus_wdata = 0; irq_in = 0; cpu_active = 8'hFF; req_ready = 1;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;

    // R5 reset state
    bus_acc(8'h00, 1, 0, 0, q); check("R5 select", q, 32'h0);
    rd_reg(8'h00, q); check("R5 id", q, 32'h0);
    rd_reg(8'h10, q); check("R5 entry0 lo", q, 32'h0001_0000);
    rd_reg(8'h2F, q); check("R5 entry15 hi", q, 32'h0001_0000);
    // R3 version and arbitration
    rd_reg(8'h01, q); check("R3 version", q, 32'h0010_0011);
    // R4 unmatched indices
    rd_reg(8'h03, q); check("R4 idx3", q, 32'h0);
    rd_reg(8'h30, q); check("R4 idx30", q, 32'h0);
    // R4 id field
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_reg(8'h00, q); check("R4 id kept bits", q, 32'h0F00_0000);
    rd_reg(8'h02, q); check("R3 arb echo", q, 32'h0F00_0000);
    wr_reg(8'h01, 32'h0); rd_reg(8'h01, q); check("R3 version ro", q, 32'h0010_0011);
    wr_reg(8'h02, 32'h0); rd_reg(8'h02, q); check("R3 arb ro", q, 32'h0F00_0000);
    // R2 select full width
    bus_acc(8'h00, 1, 1, 32'h1234_5678, q);
    bus_acc(8'h00, 1, 0, 0, q); check("R2 select readback", q, 32'h1234_5678);
    bus_acc(8'h10, 1, 0, 0, q); check("R2 window low byte 0x78", q, 32'h0);
    // R1 bad size and offset
    bus_acc(8'h00, 0, 1, 32'h0, q);
    bus_acc(8'h04, 1, 1, 32'h0, q);
    bus_acc(8'h00, 1, 0, 0, q); check("R1 select untouched", q, 32'h1234_5678);
    bus_acc(8'h04, 1, 0, 0, q); check("R1 offset4 reads zero", q, 32'h0);
    bus_acc(8'h00, 0, 0, 0, q); check("R1 narrow read zero", q, 32'h0);
    wr_reg(8'h00, 32'h0300_0000);
    bus_acc(8'h10, 0, 1, 32'h0F00_0000, q);
    rd_reg(8'h00, q); check("R1 narrow window write ignored", q, 32'h0300_0000);

    // R6 R8 R9 unicast
    set_entry(3, 32'h0200_0000, 32'h0000_0041);
    rd_reg(8'h16, q); check("R6 entry3 lo", q, 32'h0000_0041);
    rd_reg(8'h17, q); check("R6 entry3 hi", q, 32'h0200_0000);
    exp_q.push_back({8'h41, 8'h04});
    set_pin(3, 1);
    quiet("R8 unicast delivered", 8);
    // R7 hold and fall
    repeat (4) @(posedge clk);
    set_pin(3, 0);
    quiet("R7 no delivery on hold or fall", 8);
    // R9 broadcast
    set_entry(5, 32'hFF00_0000, 32'h0000_0052);
    cpu_active = 8'hA5;
    exp_q.push_back({8'h52, 8'hA5});
    set_pin(5, 1);
    quiet("R9 broadcast", 8);
    // R9 destination out of range
    set_entry(4, 32'h0900_0000, 32'h0000_0044);
    exp_q.push_back({8'h44, 8'h00});
    set_pin(4, 1);
    quiet("R9 out of range dest", 8);
    // R8 non-fixed delivery and logical mode
    set_entry(6, 32'h0000_0000, 32'h0000_0153);
    set_entry(7, 32'h0000_0000, 32'h0000_0854);
    set_pin(6, 1); set_pin(7, 1);
    quiet("R8 non-fixed and logical ignored", 10);
    // R10 masked edge dropped
    set_entry(8, 32'h0000_0000, 32'h0001_0060);
    set_pin(8, 1);
    quiet("R10 masked edge no delivery", 6);
    wr_reg(8'h20, 32'h0000_0060);
    quiet("R10 masked edge not replayed", 8);
    // R11 pending replay with line high
    set_entry(9, 32'h0100_0000, 32'h0001_8070);
    set_pin(9, 1);
    quiet("R10 masked level deferred", 8);
    exp_q.push_back({8'h70, 8'h02});
    wr_reg(8'h22, 32'h0000_8070);
    quiet("R11 replay on unmask", 8);
    wr_reg(8'h22, 32'h0001_8070);
    wr_reg(8'h22, 32'h0000_8070);
    quiet("R11 pending cleared after replay", 8);
    // R11 pending dropped with line low
    set_entry(10, 32'h0000_0000, 32'h0001_8071);
    set_pin(10, 1);
    set_pin(10, 0);
    wr_reg(8'h24, 32'h0000_8071);
    quiet("R11 pending dropped line low", 8);

    // R12 simultaneous rises with a stalled consumer
    cpu_active = 8'hFF;
    set_entry(11, 32'h0000_0000, 32'h0000_00B1);
    set_entry(12, 32'h0100_0000, 32'h0000_00B2);
    set_entry(13, 32'h0200_0000, 32'h0000_00B3);
    @(posedge clk); #1;
    req_ready = 0;
    exp_q.push_back({8'hB1, 8'h01});
    exp_q.push_back({8'hB2, 8'h02});
    exp_q.push_back({8'hB3, 8'h04});
    irq_in[13:11] = 3'b111;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R12 stalled valid", req_valid, 1);
    check("R12 stalled lowest first", {req_vector, req_cpus}, {8'hB1, 8'h01});
    @(posedge clk); #1;
    req_ready = 1;
    quiet("R12 all three drained", 10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule